// File: doc/BRIEF.md
# Multi-lane serial flash read controller

This block is the host side of a serial NOR flash read path. A request gives one of six read variants, a 32-bit start address and a byte count. The controller then runs a single chip-select-low transaction. It sends an 8-bit opcode, a 32-bit address, the dummy clocks when the variant needs them, and then the data clocks. Each received byte is delivered on an 8-bit stream with a one-cycle valid strobe. The flash advances its own address after every byte, so one transaction returns any number of consecutive bytes, up to the width of the count.

The variant selects how many data lines carry the address and how many carry the data. Single-lane phases use DQ0 for output and DQ1 for input. Two-lane phases use DQ[1:0] and four-lane phases use DQ[3:0]. The 4-bit data bus is presented as an output value, a per-lane output enable and an input value, which the pad ring combines into the bidirectional pins. Only single-transfer-rate timing is produced. The serial clock idles low and is derived from the system clock by an even divider.

Top module: `serial_flash_reader`

## Requirements
- R1: A request is accepted on a rising edge where `req_valid` is 1, `busy` is 0, `req_mode` is 0 to 5 and `req_len` is nonzero. `busy` is 1 from the next cycle until the transaction ends. Requests with mode 6 or 7, with count 0, or made while busy change nothing.
- R2: The opcode depends on the mode: 0→0x13, 1→0x0C, 2→0x3C, 3→0xBC, 4→0x6C, 5→0xEC.
- R3: After `cs_n` falls, the 8 opcode bits go out on DQ0 most significant bit first, one bit per serial clock. The 32 address bits follow, most significant first.
- R4: The address uses DQ0 alone in modes 0, 1, 2 and 4 (32 clocks), DQ[1:0] in mode 3 (16 clocks) and DQ[3:0] in mode 5 (8 clocks). In each group the highest-numbered lane carries the most significant bit. `dq_oe` enables exactly the lanes in use: 4'b0001 for DQ0 only, 4'b0011 for DQ[1:0] and 4'b1111 for DQ[3:0].
- R5: Modes 1 to 5 insert DUMMY_CYCLES serial clocks after the address. Mode 0 inserts none. `dq_oe` is 0 during the dummy and data phases and while `cs_n` is high.
- R6: Data is sampled on DQ1 in modes 0 and 1, on DQ[1:0] in modes 2 and 3, and on DQ[3:0] in modes 4 and 5. Bits are assembled into bytes most significant first, with DQ1 or DQ3 holding the higher bit of each group.
- R7: `sck` is low whenever `cs_n` is high. Each serial clock is CLK_DIV system cycles low, then CLK_DIV cycles high. Outputs change only while `sck` is low. Input bits are sampled on the edge where `sck` rises.
- R8: Exactly `req_len` bytes are delivered. `rd_valid` pulses for one cycle, in the cycle where `sck` rises for the last bit of each byte. The bytes come from consecutive addresses.
- R9: `cs_n` rises at the end of the high half of the last data clock. In that cycle `done` pulses for one cycle and `busy` falls.
- R10: Between transactions `cs_n` stays high for at least 2·CS_GAP·CLK_DIV + 1 system cycles.
- R11: `cs_n` falls on the second edge after acceptance, unless R10 delays it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe |
| req_mode | input | 3 | Read variant 0..5 |
| req_addr | input | 32 | Start byte address |
| req_len | input | LEN_W | Number of bytes to read |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle end-of-transaction pulse |
| rd_data | output | 8 | Received byte |
| rd_valid | output | 1 | `rd_data` valid strobe |
| sck | output | 1 | Serial clock |
| cs_n | output | 1 | Chip select, active low |
| dq_o | output | 4 | Data lane output values |
| dq_oe | output | 4 | Per-lane output enables |
| dq_i | input | 4 | Data lane input values |

## Verification
With acceptance on edge a, `busy` is due after edge a and `cs_n` falls after edge a+1, or after the gap counted from the previous rise of `cs_n` if that is later. `sck` rises CLK_DIV cycles into each serial clock. `rd_valid` appears after the rising edge of each byte's last bit. `done` and the rise of `cs_n` come 2·CLK_DIV·N cycles after the fall of `cs_n`, where N is the number of serial clocks. The reference model computes each of these cycle numbers from the request and compares the outputs at every falling clock edge, away from the edge that updates them. A behavioural flash model decodes the opcode and address on the rising edges of `sck`. It supplies data during the low halves and drives inverted or constant values on the unused lanes, so a wrong lane choice or a wrong sampling point shows up as a wrong byte.

// File: rtl/serial_flash_reader.sv
module serial_flash_reader #(
  parameter int CLK_DIV      = 2,
  parameter int DUMMY_CYCLES = 8,
  parameter int CS_GAP       = 2,
  parameter int LEN_W        = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [2:0]       req_mode,
  input  logic [31:0]      req_addr,
  input  logic [LEN_W-1:0] req_len,
  output logic             busy,
  output logic             done,
  output logic [7:0]       rd_data,
  output logic             rd_valid,
  output logic             sck,
  output logic             cs_n,
  output logic [3:0]       dq_o,
  output logic [3:0]       dq_oe,
  input  logic [3:0]       dq_i
);
  localparam int DW      = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam int CW      = $clog2((DUMMY_CYCLES > 32) ? DUMMY_CYCLES : 32) + 1;
  localparam int GAP_CYC = CS_GAP * 2 * CLK_DIV;
  localparam int GW      = $clog2(GAP_CYC + 1);

  typedef enum logic [2:0] {S_IDLE, S_WAIT, S_CMD, S_ADDR, S_DUMMY, S_DATA} st_t;

  st_t              st;
  logic [2:0]       mode_q;
  logic [39:0]      sh;
  logic [CW-1:0]    cnt;
  logic [LEN_W-1:0] left;
  logic [DW-1:0]    div;
  logic [GW-1:0]    gap;
  logic [7:0]       rx, rx_nx;
  logic [2:0]       al, dl;
  logic [7:0]       op;
  logic             last_div, req_ok;
  logic [CW-1:0]    a_slots, d_slots;

  assign al = (mode_q == 3'd3) ? 3'd2 : (mode_q == 3'd5) ? 3'd4 : 3'd1;
  assign dl = (mode_q <= 3'd1) ? 3'd1 : (mode_q <= 3'd3) ? 3'd2 : 3'd4;
  assign a_slots = (al == 3'd1) ? CW'(31) : (al == 3'd2) ? CW'(15) : CW'(7);
  assign d_slots = (dl == 3'd1) ? CW'(7) : (dl == 3'd2) ? CW'(3) : CW'(1);
  assign last_div = (div == DW'(CLK_DIV - 1));
  assign req_ok = req_valid && !busy && (req_mode <= 3'd5) && (req_len != '0);

  always_comb begin
    case (req_mode)
      3'd0:    op = 8'h13;
      3'd1:    op = 8'h0C;
      3'd2:    op = 8'h3C;
      3'd3:    op = 8'hBC;
      3'd4:    op = 8'h6C;
      default: op = 8'hEC;
    endcase
  end

  always_comb begin
    case (dl)
      3'd1:    rx_nx = {rx[6:0], dq_i[1]};
      3'd2:    rx_nx = {rx[5:0], dq_i[1:0]};
      default: rx_nx = {rx[3:0], dq_i};
    endcase
  end

  always_comb begin
    dq_o  = 4'b0000;
    dq_oe = 4'b0000;
    if (st == S_CMD) begin
      dq_o  = {3'b000, sh[39]};
      dq_oe = 4'b0001;
    end else if (st == S_ADDR) begin
      case (al)
        3'd4: begin dq_o = sh[39:36];          dq_oe = 4'b1111; end
        3'd2: begin dq_o = {2'b00, sh[39:38]}; dq_oe = 4'b0011; end
        default: begin dq_o = {3'b000, sh[39]}; dq_oe = 4'b0001; end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      mode_q   <= '0;
      sh       <= '0;
      cnt      <= '0;
      left     <= '0;
      div      <= '0;
      gap      <= '0;
      rx       <= '0;
      rd_data  <= '0;
      rd_valid <= 1'b0;
      busy     <= 1'b0;
      done     <= 1'b0;
      sck      <= 1'b0;
      cs_n     <= 1'b1;
    end else begin
      done     <= 1'b0;
      rd_valid <= 1'b0;
      if (gap != '0) gap <= gap - GW'(1);
      case (st)
        S_IDLE: if (req_ok) begin
          mode_q <= req_mode;
          sh     <= {op, req_addr};
          left   <= req_len;
          busy   <= 1'b1;
          st     <= S_WAIT;
        end
        S_WAIT: if (gap == '0) begin
          cs_n <= 1'b0;
          sck  <= 1'b0;
          div  <= '0;
          cnt  <= CW'(7);
          st   <= S_CMD;
        end
        default: begin
          if (!last_div) begin
            div <= div + DW'(1);
          end else begin
            div <= '0;
            sck <= !sck;
            if (!sck) begin
              if (st == S_DATA) begin
                rx <= rx_nx;
                if (cnt == '0) begin
                  rd_data  <= rx_nx;
                  rd_valid <= 1'b1;
                end
              end
            end else begin
              case (st)
                S_CMD: begin
                  sh <= sh << 1;
                  if (cnt == '0) begin
                    st  <= S_ADDR;
                    cnt <= a_slots;
                  end else cnt <= cnt - CW'(1);
                end
                S_ADDR: begin
                  sh <= sh << al;
                  if (cnt == '0) begin
                    if (mode_q != 3'd0) begin
                      st  <= S_DUMMY;
                      cnt <= CW'(DUMMY_CYCLES - 1);
                    end else begin
                      st  <= S_DATA;
                      cnt <= d_slots;
                    end
                  end else cnt <= cnt - CW'(1);
                end
                S_DUMMY: begin
                  if (cnt == '0) begin
                    st  <= S_DATA;
                    cnt <= d_slots;
                  end else cnt <= cnt - CW'(1);
                end
                default: begin
                  if (cnt == '0) begin
                    if (left == LEN_W'(1)) begin
                      st   <= S_IDLE;
                      cs_n <= 1'b1;
                      busy <= 1'b0;
                      done <= 1'b1;
                      gap  <= GW'(GAP_CYC);
                    end else begin
                      left <= left - LEN_W'(1);
                      cnt  <= d_slots;
                    end
                  end else cnt <= cnt - CW'(1);
                end
              endcase
            end
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/serial_flash_reader_chk.sv
module serial_flash_reader_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       done,
  input logic       rd_valid,
  input logic       sck,
  input logic       cs_n,
  input logic [3:0] dq_oe
);
  // R7
  idle_sck_low_chk: assert property (@(posedge clk) disable iff (!rst_n) cs_n |-> !sck);
  // R9
  done_end_chk: assert property (@(posedge clk) disable iff (!rst_n) done |-> (cs_n && !busy));
  // R9
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  // R5
  idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n) cs_n |-> (dq_oe == 4'b0000));
  // R1
  select_busy_chk: assert property (@(posedge clk) disable iff (!rst_n) $fell(cs_n) |-> busy);
  // R8
  strobe_active_chk: assert property (@(posedge clk) disable iff (!rst_n) rd_valid |-> (!cs_n && busy));
  // R4
  lane_group_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dq_oe == 4'b0000) || (dq_oe == 4'b0001) || (dq_oe == 4'b0011) || (dq_oe == 4'b1111));
  // R7
  sck_select_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(sck) |-> !cs_n);
endmodule

bind serial_flash_reader serial_flash_reader_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .rd_valid(rd_valid),
  .sck(sck), .cs_n(cs_n), .dq_oe(dq_oe)
);

// File: tb/tb_serial_flash_reader.sv
module tb_serial_flash_reader;
  localparam int CLK_PERIOD = 10;
  localparam int D    = 2;
  localparam int DUM  = 8;
  localparam int GAPS = 2;
  localparam int LW   = 16;
  localparam int G    = GAPS * 2 * D;

  logic          clk = 1'b0, rst_n = 1'b0, req_valid = 1'b0;
  logic [2:0]    req_mode = '0;
  logic [31:0]   req_addr = '0;
  logic [LW-1:0] req_len = '0;
  logic [3:0]    dq_i = 4'hF;
  logic          busy, done, rd_valid, sck, cs_n;
  logic [7:0]    rd_data;
  logic [3:0]    dq_o, dq_oe;

  serial_flash_reader #(.CLK_DIV(D), .DUMMY_CYCLES(DUM), .CS_GAP(GAPS), .LEN_W(LW)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
    .req_addr(req_addr), .req_len(req_len), .busy(busy), .done(done),
    .rd_data(rd_data), .rd_valid(rd_valid), .sck(sck), .cs_n(cs_n),
    .dq_o(dq_o), .dq_oe(dq_oe), .dq_i(dq_i));

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0, errors = 0;
  int t_acc = -1000000, t_s = -1000000, t_end = -1000000, last_end = -1000000;
  int m_mode = 0, m_len = 0, rises = 0, bidx = 0, rise_c = -1000000;
  logic [31:0] m_addr = '0, f_addr = '0;
  logic [7:0]  f_op = '0;
  logic prev_sck = 1'b0, prev_cs = 1'b1;

  function automatic int alanes(int m); return (m == 3) ? 2 : (m == 5) ? 4 : 1; endfunction
  function automatic int dlanes(int m); return (m <= 1) ? 1 : (m <= 3) ? 2 : 4; endfunction
  function automatic int hdr(int m); return 8 + 32 / alanes(m) + ((m != 0) ? DUM : 0); endfunction
  function automatic logic [7:0] opc(int m);
    case (m) 0: return 8'h13; 1: return 8'h0C; 2: return 8'h3C;
             3: return 8'hBC; 4: return 8'h6C; default: return 8'hEC; endcase
  endfunction
  function automatic logic [7:0] mem(logic [31:0] a);
    logic [7:0] t;
    t = a[7:0] * 8'd37;
    return t ^ a[15:8] ^ a[31:24] ^ 8'hA5;
  endfunction

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      int c, rel, slot, dlw, al, h;
      bit in_tx, e_sck, e_rv;
      logic [3:0] e_oe;
      c = cyc; al = alanes(m_mode); dlw = dlanes(m_mode); h = hdr(m_mode);
      in_tx = (c >= t_s) && (c < t_end);
      rel = c - t_s; slot = in_tx ? rel / (2 * D) : 0;
      e_sck = in_tx && ((rel % (2 * D)) >= D);
      e_oe = 4'b0000;
      if (in_tx && slot < 8) e_oe = 4'b0001;
      else if (in_tx && slot < 8 + 32 / al) e_oe = (al == 4) ? 4'b1111 : (al == 2) ? 4'b0011 : 4'b0001;
      e_rv = in_tx && ((rel % (2 * D)) == D) && (slot >= h) && (((slot - h) % (8 / dlw)) == 8 / dlw - 1);
      chk(cs_n == !in_tx, "R11 cs_n", 32'(cs_n), 32'(!in_tx));
      chk(sck == e_sck, "R7 sck", 32'(sck), 32'(e_sck));
      chk(busy == ((c >= t_acc) && (c < t_end)), "R1 busy", 32'(busy), 32'((c >= t_acc) && (c < t_end)));
      chk(done == (c == t_end), "R9 done", 32'(done), 32'(c == t_end));
      chk(dq_oe == e_oe, "R5 lane enables", 32'(dq_oe), 32'(e_oe));
      chk(rd_valid == e_rv, "R8 rd_valid", 32'(rd_valid), 32'(e_rv));

      if (rd_valid) begin
        chk(rd_data == mem(m_addr + 32'(bidx)), "R6 data byte", 32'(rd_data), 32'(mem(m_addr + 32'(bidx))));
        bidx++;
      end
      if (!cs_n && prev_cs) begin
        if (rise_c > -1000000) chk(c - rise_c >= G + 1, "R10 cs gap", 32'(c - rise_c), 32'(G + 1));
        rises = 0;
      end
      if (!cs_n && sck && !prev_sck) begin
        if (rises < 8) f_op = {f_op[6:0], dq_o[0]};
        else if (rises < 8 + 32 / al) begin
          if (al == 4) f_addr = {f_addr[27:0], dq_o};
          else if (al == 2) f_addr = {f_addr[29:0], dq_o[1:0]};
          else f_addr = {f_addr[30:0], dq_o[0]};
        end
        rises++;
      end
      if (cs_n && !prev_cs) begin
        rise_c = c;
        chk(f_op == opc(m_mode), "R2 opcode", 32'(f_op), 32'(opc(m_mode)));
        chk(f_addr == m_addr, (al == 1) ? "R3 address" : "R4 address", f_addr, m_addr);
        chk(rises == h + m_len * 8 / dlw, "R5 clock count", 32'(rises), 32'(h + m_len * 8 / dlw));
        chk(bidx == m_len, "R8 byte count", 32'(bidx), 32'(m_len));
      end
      if (!cs_n && !sck && rises >= h) begin
        int k, j;
        logic [7:0] b;
        k = rises - h;
        b = mem(m_addr + 32'(k / (8 / dlw)));
        j = k % (8 / dlw);
        if (dlw == 1) dq_i = {2'b10, b[7 - j], ~b[7 - j]};
        else if (dlw == 2) dq_i = {2'b01, b[7 - 2 * j -: 2]};
        else dq_i = b[7 - 4 * j -: 4];
      end else dq_i = 4'hF;
      prev_sck = sck;
      prev_cs = cs_n;
    end
  end

  task automatic request(int mode, logic [31:0] addr, int len);
    int c;
    @(negedge clk); #1;
    c = cyc;
    req_valid = 1'b1; req_mode = 3'(mode); req_addr = addr; req_len = LW'(len);
    if (!((c >= t_acc) && (c < t_end)) && mode <= 5 && len != 0) begin
      t_acc = c + 1;
      t_s = (t_acc + 1 > last_end + G + 1) ? t_acc + 1 : last_end + G + 1;
      m_mode = mode; m_addr = addr; m_len = len; bidx = 0;
      t_end = t_s + 2 * D * (hdr(mode) + len * 8 / dlanes(mode));
      last_end = t_end;
    end
    @(negedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic wait_end();
    while (cyc <= t_end + 1) @(negedge clk);
  endtask

  always @(posedge clk) if (cyc > 150000) begin
    errors++;
    $display("FAIL watchdog: actual %0d expected below 150000", cyc);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    chk(cs_n == 1'b1 && sck == 1'b0, "R7 reset pins", 32'({cs_n, sck}), 32'h2);
    chk(busy == 1'b0 && done == 1'b0 && rd_valid == 1'b0, "R1 reset flags", 32'({busy, done, rd_valid}), 32'h0);
    chk(dq_oe == 4'b0000, "R5 reset enables", 32'(dq_oe), 32'h0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    request(0, 32'h0000_0010, 3);     wait_end();
    request(1, 32'h1234_5678, 2);     wait_end();
    request(2, 32'hA5A5_0F0F, 4);     wait_end();
    request(3, 32'h8000_0001, 3);     wait_end();
    request(4, 32'hFFFF_FFFE, 4);     wait_end();
    request(5, 32'h0BAD_CAFE, 5);     wait_end();
    request(6, 32'h0000_0100, 2);
    repeat (20) @(negedge clk);
    chk(busy == 1'b0 && cs_n == 1'b1, "R1 bad mode ignored", 32'({busy, cs_n}), 32'h1);
    request(2, 32'h0000_0200, 0);
    repeat (20) @(negedge clk);
    chk(busy == 1'b0 && cs_n == 1'b1, "R1 zero count ignored", 32'({busy, cs_n}), 32'h1);
    request(5, 32'h4000_0040, 2);
    repeat (30) @(negedge clk);
    request(0, 32'h7777_0000, 1);
    wait_end();
    request(1, 32'h0000_00FF, 1);
    while (cyc < t_end) @(negedge clk);
    request(4, 32'h0001_0000, 2);     wait_end();
    repeat (10) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule